// File: doc/BRIEF.md
# Hall Position Capture with Commutation Blanking

This block takes the three raw Hall-effect sensor lines of a brushless motor, brings them into the system clock domain and keeps a registered copy of the rotor position code. The register follows the inputs while nothing is happening. When the synchronised code differs from the held code, the register loads the new code and freezes, so that switching noise around a commutation cannot cause extra commutations.

Each accepted load raises a one-cycle load strobe. It also starts a tachometer pulse whose width is a fixed number of system clock cycles. The average of that pulse train is proportional to rotor speed. The freeze ends only when two conditions are both met: the tachometer pulse has finished, and a set number of PWM oscillator tick strobes have arrived after the load. A code change that appears during the freeze is not stored. When the freeze ends, the current code is compared with the held code again.

The commutation decoder, the PWM generator and the filter that turns the tachometer pulse into a speed voltage sit outside this block.

Top module: `hall_blank_latch`

## Requirements
- R1: A change on the raw Hall inputs, held steady, reaches the position output and the load strobe as follows, provided the block is not frozen. It is not visible after the second rising clock edge that samples it. It is visible after the third.
- R2: A capture loads all three bits of the synchronised code at once, for every pair of distinct old and new codes. The code is bit 0 = first sensor, bit 1 = second sensor and bit 2 = third sensor.
- R3: The load strobe is high for exactly one clock cycle per capture, and it is high only in cycles where the position output has just changed.
- R4: The tachometer output rises together with the load strobe. It stays high for exactly TACH_CYCLES clock cycles.
- R5: While the tachometer output is high, the position output does not change, even after the tick count has expired.
- R6: After a capture, the position output stays frozen until HOLD_TICKS PWM tick strobes have been sampled on clock edges after the capture edge. A tick sampled on the capture edge itself is not counted.
- R7: Code changes during the frozen window are not queued. When the window ends, a code that still differs from the held one is captured on the next edge. A code that has returned to the held value causes no load.
- R8: During reset the load strobe and tachometer output are low, and the position output takes the synchronised code. Leaving reset with steady inputs produces no load and no tachometer pulse. Reset asserted in the middle of a pulse clears the tachometer output after one edge.
- R9: While the synchronised code equals the held code, no load occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_tick | input | 1 | One-cycle strobe, once per PWM oscillator period |
| hall_raw | input | 3 | Asynchronous Hall sensor inputs |
| pos_q | output | 3 | Held rotor position code |
| tach_out | output | 1 | Fixed-width tachometer pulse |
| load_stb | output | 1 | One-cycle strobe marking each capture |

## Verification
A raw input change is due on `pos_q` and `load_stb` on the third rising edge: two synchroniser flops and then the capture register. The bench therefore checks just after the second edge that nothing has moved yet, and just after the third that the new code is there. The tachometer width is measured by counting the falling-edge samples in which the output is high, starting with the capture sample. The end of the freeze is located by driving single-cycle tick strobes from the bench and checking the cycle before the release edge and the cycle after it. All inputs change on falling edges and all samples are taken on falling edges, so every expected value is tied to a known count of rising edges.

// File: rtl/hall_blank_pkg.sv
// Package: shared types and constants for the Hall capture/blanking block.
// Assumes three Hall sensors; the code width is fixed by the motor geometry.
package hall_blank_pkg;
    localparam int HALL_W = 3;
    typedef logic [HALL_W-1:0] hall_code_t;
endpackage

// File: rtl/hbl_sync.sv
// Module: multi-stage synchroniser for asynchronous level inputs.
// Assumes inputs change slowly relative to clk. The flops carry no reset on
// purpose, so that the synchronised code is valid while reset is asserted.
module hbl_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [STAGES];

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        stage[0] <= din;
        for (int i = 1; i < STAGES; i++) begin
            stage[i] <= stage[i-1];
        end
    end

    assign dout = stage[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk2
            // Output follows the input two edges later.
            p_sync_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
                dout == $past(din, 2))
                else $error("sync latency broken");
        end
    endgenerate
endmodule

// File: rtl/hbl_pulse_timer.sv
// Module: fixed-width pulse generator counted in system clock cycles.
// Assumes start is only raised while the timer is idle.
module hbl_pulse_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt;

    // Load the width on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= LOAD;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // The capture logic must never retrigger a running pulse.
    p_no_retrigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy)
        else $error("pulse retriggered while busy");

    // A started pulse is visible on the next cycle.
    p_start_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy)
        else $error("pulse did not start");
endmodule

// File: rtl/hbl_tick_window.sv
// Module: hold window counted in PWM tick strobes.
// Assumes tick is a single-cycle strobe. A tick in the start cycle is not counted.
module hbl_tick_window #(
    parameter int TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] LOAD = TW'(TICKS);

    logic [TW-1:0] left;

    // Reload on start; consume one tick per strobe while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                     left <= '0;
        else if (start)                 left <= LOAD;
        else if (tick && left != '0)    left <= left - 1'b1;
    end

    assign busy = (left != '0);

    // Once idle, the window stays idle until a new start.
    p_idle_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy)
        else $error("window reopened without start");

    // Without a tick the window cannot close.
    p_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !start) |=> busy)
        else $error("window closed without tick");
endmodule

// File: rtl/hall_blank_latch.sv
// Module: Hall position capture with commutation blanking and tach pulse.
// Assumes pwm_tick is a one-cycle strobe in the clk domain and hall_raw is
// asynchronous. Reset is synchronous, active low.
module hall_blank_latch
    import hall_blank_pkg::*;
#(
    parameter int TACH_CYCLES = 64,
    parameter int HOLD_TICKS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_tick,
    input  logic [HALL_W-1:0] hall_raw,
    output logic [HALL_W-1:0] pos_q,
    output logic              tach_out,
    output logic              load_stb
);
    hall_code_t hall_s;
    hall_code_t pos_r;
    logic       load_r;
    logic       win_busy;
    logic       take;

    hbl_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (hall_raw),
        .dout (hall_s)
    );

    // Capture when neither hold source is active and the code moved.
    assign take = !tach_out && !win_busy && (hall_s != pos_r);

    hbl_pulse_timer #(.CYCLES(TACH_CYCLES)) u_tach (
        .clk (clk),
        .rst_n (rst_n),
        .start (take),
        .busy (tach_out)
    );

    hbl_tick_window #(.TICKS(HOLD_TICKS)) u_window (
        .clk (clk),
        .rst_n (rst_n),
        .start (take),
        .tick (pwm_tick),
        .busy (win_busy)
    );

    // Position register: track during reset, capture on accepted change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_r  <= hall_s;
            load_r <= 1'b0;
        end else begin
            load_r <= take;
            if (take) pos_r <= hall_s;
        end
    end

    assign pos_q    = pos_r;
    assign load_stb = load_r;

    // Any movement of the held code is marked by the strobe.
    p_change_marked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pos_q) |-> load_stb)
        else $error("position changed without load");

    // Strobe lasts one cycle.
    p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb)
        else $error("load strobe longer than a cycle");

    // Tach rises with the load.
    p_load_tach_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> tach_out)
        else $error("load without tach");

    // Held while tach is high.
    p_tach_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tach_out |=> $stable(pos_q))
        else $error("position moved under tach pulse");

    // Held while the tick window runs.
    p_window_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_busy |=> !load_stb)
        else $error("load inside blanking window");
endmodule

// File: tb/hall_blank_latch_bench.sv
`timescale 1ns/1ps
module hall_blank_latch_bench;
    localparam int TW = 4;
    localparam int HT = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_tick = 1'b0;
    logic [2:0] hall_raw = 3'd0;
    logic [2:0] pos_q;
    logic       tach_out;
    logic       load_stb;

    int checks = 0;
    int errors = 0;
    int loads  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    hall_blank_latch #(.TACH_CYCLES(TW), .HOLD_TICKS(HT), .SYNC_STAGES(2)) u_hall_blank_latch (
        .clk (clk), .rst_n (rst_n), .pwm_tick (pwm_tick),
        .hall_raw (hall_raw), .pos_q (pos_q), .tach_out (tach_out), .load_stb (load_stb)
    );

    // Count load pulses once per cycle, away from the active edge.
    always @(negedge clk) if (load_stb) loads++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick_pulse();
        pwm_tick = 1'b1;
        edges(1);
        pwm_tick = 1'b0;
    endtask

    // Wait for tach to end, then supply the hold ticks.
    task automatic release_window();
        int guard = 0;
        while (tach_out && guard < 100) begin edges(1); guard++; end
        for (int i = 0; i < HT; i++) tick_pulse();
    endtask

    // Apply a new code, check latency, strobe and pulse width.
    task automatic capture(input logic [2:0] code, input bit tick_on_capture);
        logic [2:0] old = pos_q;
        int hi;
        hall_raw = code;
        edges(2);
        chk(pos_q == old && !load_stb, "R1 early", pos_q, old);
        if (tick_on_capture) pwm_tick = 1'b1;
        edges(1);
        pwm_tick = 1'b0;
        chk(pos_q == code, "R2 code", pos_q, code);
        chk(load_stb && tach_out, "R1 strobe+tach", {load_stb, tach_out}, 3);
        hi = 1;
        for (int i = 0; i < TW + 3; i++) begin
            edges(1);
            if (i == 0) chk(!load_stb, "R3 single", load_stb, 0);
            if (tach_out) hi++;
        end
        chk(hi == TW, "R4 width", hi, TW);
    endtask

    initial begin
        int l0;
        // R8: reset with a steady code.
        hall_raw = 3'd5;
        edges(5);
        chk(pos_q == 3'd5 && !tach_out && !load_stb, "R8 reset", {pos_q, tach_out, load_stb}, 5 << 2);
        rst_n = 1'b1;
        edges(8);
        chk(loads == 0 && !tach_out && pos_q == 3'd5, "R8 quiet exit", loads, 0);

        // R9: steady inputs do nothing, ticks or not.
        for (int i = 0; i < 6; i++) tick_pulse();
        chk(loads == 0, "R9 steady", loads, 0);

        // R1/R2/R3/R4: every ordered pair of distinct codes.
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                if (a == b) continue;
                if (pos_q != 3'(a)) begin capture(3'(a), 0); release_window(); end
                l0 = loads;
                capture(3'(b), 0);
                chk(loads == l0 + 1, "R3 count", loads, l0 + 1);
                release_window();
                edges(1);
            end
        end

        // R6/R7: tick on capture edge not counted; late code captured at window end.
        capture(3'd3, 1);
        hall_raw = 3'd6;
        tick_pulse();
        edges(TW + 4);
        chk(pos_q == 3'd3, "R6 one tick holds", pos_q, 3);
        pwm_tick = 1'b1;
        edges(1);
        pwm_tick = 1'b0;
        chk(pos_q == 3'd3 && !load_stb, "R6 before release", pos_q, 3);
        edges(1);
        chk(pos_q == 3'd6 && load_stb, "R7 captured at end", pos_q, 6);
        release_window();
        edges(2);

        // R7: a glitch inside the window that returns is dropped.
        capture(3'd1, 0);
        l0 = loads;
        hall_raw = 3'd4;
        edges(4);
        hall_raw = 3'd1;
        edges(4);
        release_window();
        edges(6);
        chk(pos_q == 3'd1 && loads == l0, "R7 not queued", loads, l0);

        // R5: window expired, tach still high holds the code.
        hall_raw = 3'd2;
        edges(3);
        chk(pos_q == 3'd2, "R5 setup", pos_q, 2);
        hall_raw = 3'd7;
        pwm_tick = 1'b1;
        edges(2);
        pwm_tick = 1'b0;
        edges(TW - 2);
        chk(pos_q == 3'd2 && !tach_out, "R5 held under tach", pos_q, 2);
        edges(1);
        chk(pos_q == 3'd7 && load_stb, "R5 release", pos_q, 7);

        // R8: reset mid-pulse clears tach.
        edges(1);
        rst_n = 1'b0;
        edges(1);
        chk(!tach_out && !load_stb, "R8 reset mid pulse", tach_out, 0);
        rst_n = 1'b1;
        edges(4);
        chk(!tach_out && pos_q == 3'd7, "R8 after reset", pos_q, 7);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule